// File: doc/BRIEF.md
# Block-Granular Register File Allocator

This block hands out the vector registers of one execution engine to the hardware threads that run on it. The register file has 1024 registers of 512 bits each (64 KB). It is carved into 32 blocks of 32 registers, and up to 10 threads can be resident at once. A thread that asks for a register count receives a contiguous run of whole blocks. Occupancy therefore falls off gradually as the per-thread need grows, instead of stepping between a few fixed splits.

A launch request carries the number of registers the thread needs. The allocator rounds this up to whole blocks. It picks the lowest-numbered idle thread slot and the lowest-addressed contiguous run of free blocks that is long enough. One cycle later it answers with the slot number and the base block index. It refuses the request when the size is illegal, when every slot is busy, or when no run is long enough; a refused request changes nothing. A retire request names a slot, and that slot's blocks become free. Two occupancy counts are always visible: the number of resident threads and the number of free blocks.

Top module: `rfa_alloc`

## Requirements
- R1: After reset no thread is resident, all 32 blocks are free (`free_blocks` = 32, `live_threads` = 0) and `resp_valid` is low.
- R2: A granted request for n registers occupies ceil(n/32) blocks. For example, 1 register takes 1 block, 33 take 2, 96 take 3 and 256 take 8.
- R3: The granted base is the lowest block index b where blocks b to b+need-1 are all free (first fit). It is reported on `resp_base` as a block number from 0 to 31.
- R4: A granted request is given the lowest-numbered idle slot (0 to 9), reported on `resp_tid`.
- R5: A request for 0 registers or for more than 256 registers answers with `resp_err` and leaves the slots and blocks untouched.
- R6: When all 10 slots are resident, a legal request answers with `resp_full` and changes nothing.
- R7: When no contiguous free run is long enough, a legal request answers with `resp_full` and allocates no block, even if enough blocks are free in total.
- R8: A retire of a resident slot frees its blocks and the slot. A request in the same cycle as the retire does not see those blocks; a request in the next cycle does.
- R9: A retire naming an idle slot, or a slot number of 10 or above, has no effect.
- R10: Ten threads of 96 registers each are all granted, which leaves 2 blocks free.
- R11: Every request gets exactly one answer, in the cycle after it was presented: `resp_valid` with exactly one of `resp_ok`, `resp_err`, `resp_full`. With no request, `resp_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_valid | input | 1 | Launch request this cycle |
| alloc_regs | input | 10 | Registers needed by the launching thread |
| retire_valid | input | 1 | Retire request this cycle |
| retire_tid | input | 4 | Slot being retired |
| resp_valid | output | 1 | Answer to the previous cycle's request |
| resp_ok | output | 1 | Request granted |
| resp_err | output | 1 | Illegal register count |
| resp_full | output | 1 | Refused: no slot or no contiguous space |
| resp_tid | output | 4 | Granted slot (0 when not granted) |
| resp_base | output | 5 | Granted base block (0 when not granted) |
| live_threads | output | 4 | Number of resident threads |
| free_blocks | output | 6 | Number of free blocks |

## Verification
The bench tries grants from an empty file with sizes 1, 33, 256 and the illegal 0 and 257, so that rounding, the size limits and first-fit base choice can be told apart. Holes opened by retiring middle threads show whether the search reuses the lowest gap and the lowest idle slot, rather than appending. A full-occupancy run of ten 96-register threads followed by an eleventh request separates slot exhaustion from space exhaustion. A fragmented layout with enough total free blocks but no long run shows that no partial grant happens. A retire issued together with a request shows that freed blocks are only visible one cycle later.

// File: rtl/rfa_pkg.sv
// Shared types for the register file allocator.
// Assumes: nothing beyond the parameters of the users.
package rfa_pkg;
    // Outcome of one launch request.
    typedef enum logic [1:0] {
        OUT_OK   = 2'd0,
        OUT_ERR  = 2'd1,
        OUT_FULL = 2'd2
    } outcome_t;
endpackage

// File: rtl/rfa_fit_finder.sv
// First-fit search: finds the lowest base block whose window of NEED
// consecutive blocks is fully free inside the file.
// Assumes: need is at least 1; purely combinational.
module rfa_fit_finder #(
    parameter int NUM_BLOCKS = 32,
    parameter int NEED_W     = 4,
    localparam int BASE_W    = $clog2(NUM_BLOCKS)
) (
    input  logic [NUM_BLOCKS-1:0] free_mask,
    input  logic [NEED_W-1:0]     need,
    output logic                  found,
    output logic [BASE_W-1:0]     base
);
    logic [NUM_BLOCKS-1:0] fits;

    // One window test per candidate base.
    for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_base
        always_comb begin
            fits[b] = (b + int'(need)) <= NUM_BLOCKS;
            for (int j = 0; j < NUM_BLOCKS; j++) begin
                if (j >= b && j < b + int'(need) && !free_mask[j])
                    fits[b] = 1'b0;
            end
        end
    end

    // Priority encode the lowest fitting base.
    always_comb begin
        found = 1'b0;
        base  = '0;
        for (int b = NUM_BLOCKS - 1; b >= 0; b--) begin
            if (fits[b]) begin
                found = 1'b1;
                base  = BASE_W'(b);
            end
        end
    end
endmodule

// File: rtl/rfa_slot_table.sv
// Per-thread slot table: holds residency, base and length of each slot,
// offers the lowest idle slot and the block mask of a retiring slot.
// Assumes: a write only targets an idle slot; retire of idle or
// out-of-range slot numbers is ignored.
module rfa_slot_table #(
    parameter int MAX_THREADS = 10,
    parameter int NUM_BLOCKS  = 32,
    parameter int NEED_W      = 4,
    localparam int TID_W      = $clog2(MAX_THREADS),
    localparam int BASE_W     = $clog2(NUM_BLOCKS),
    localparam int CNT_W      = $clog2(MAX_THREADS + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [TID_W-1:0]      wr_tid,
    input  logic [BASE_W-1:0]     wr_base,
    input  logic [NEED_W-1:0]     wr_len,
    input  logic                  ret_en,
    input  logic [TID_W-1:0]      ret_tid,
    output logic                  slot_avail,
    output logic [TID_W-1:0]      slot_idx,
    output logic [NUM_BLOCKS-1:0] ret_blocks,
    output logic [CNT_W-1:0]      live_count
);
    logic [MAX_THREADS-1:0] busy;
    logic [BASE_W-1:0]      base_q [MAX_THREADS];
    logic [NEED_W-1:0]      len_q  [MAX_THREADS];
    logic [MAX_THREADS-1:0] ret_hit;

    // Decode which resident slot (if any) the retire names.
    always_comb begin
        for (int t = 0; t < MAX_THREADS; t++)
            ret_hit[t] = ret_en && busy[t] && (ret_tid == TID_W'(t));
    end

    // Block mask of the retiring slot.
    always_comb begin
        ret_blocks = '0;
        for (int t = 0; t < MAX_THREADS; t++) begin
            for (int j = 0; j < NUM_BLOCKS; j++) begin
                if (ret_hit[t] && j >= int'(base_q[t]) &&
                    j < int'(base_q[t]) + int'(len_q[t]))
                    ret_blocks[j] = 1'b1;
            end
        end
    end

    // Lowest idle slot.
    always_comb begin
        slot_avail = 1'b0;
        slot_idx   = '0;
        for (int t = MAX_THREADS - 1; t >= 0; t--) begin
            if (!busy[t]) begin
                slot_avail = 1'b1;
                slot_idx   = TID_W'(t);
            end
        end
    end

    assign live_count = CNT_W'($countones(busy));

    // Slot state update: grant sets, retire clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= '0;
            for (int t = 0; t < MAX_THREADS; t++) begin
                base_q[t] <= '0;
                len_q[t]  <= '0;
            end
        end else begin
            for (int t = 0; t < MAX_THREADS; t++) begin
                if (wr_en && wr_tid == TID_W'(t)) begin
                    busy[t]   <= 1'b1;
                    base_q[t] <= wr_base;
                    len_q[t]  <= wr_len;
                end else if (ret_hit[t]) begin
                    busy[t] <= 1'b0;
                end
            end
        end
    end

    AST_RETIRE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_en && ret_hit == '0 && !wr_en) |=> $stable(busy)); // R9
    AST_WRITE_IDLE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !busy[wr_tid]); // R4
endmodule

// File: rtl/rfa_alloc.sv
// Register file allocator top: validates a launch request, rounds it to
// blocks, combines slot availability with a first-fit search, updates the
// free mask and answers one cycle later. Retires free blocks at the edge.
// Assumes: one request and one retire at most per cycle.
module rfa_alloc
    import rfa_pkg::*;
#(
    parameter int NUM_BLOCKS   = 32,
    parameter int BLOCK_REGS   = 32,
    parameter int MAX_THREADS  = 10,
    parameter int MAX_REQ_REGS = 256,
    parameter int REQ_W        = 10,
    localparam int TID_W       = $clog2(MAX_THREADS),
    localparam int BASE_W      = $clog2(NUM_BLOCKS),
    localparam int CNT_W       = $clog2(MAX_THREADS + 1),
    localparam int FB_W        = $clog2(NUM_BLOCKS + 1),
    localparam int MAX_NEED    = (MAX_REQ_REGS + BLOCK_REGS - 1) / BLOCK_REGS,
    localparam int NEED_W      = $clog2(MAX_NEED + 1),
    localparam int SHIFT       = $clog2(BLOCK_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    input  logic [REQ_W-1:0]  alloc_regs,
    input  logic              retire_valid,
    input  logic [TID_W-1:0]  retire_tid,
    output logic              resp_valid,
    output logic              resp_ok,
    output logic              resp_err,
    output logic              resp_full,
    output logic [TID_W-1:0]  resp_tid,
    output logic [BASE_W-1:0] resp_base,
    output logic [CNT_W-1:0]  live_threads,
    output logic [FB_W-1:0]   free_blocks
);
    logic [NUM_BLOCKS-1:0] free_mask;
    logic [NUM_BLOCKS-1:0] grant_mask;
    logic [NUM_BLOCKS-1:0] ret_blocks;
    logic [REQ_W:0]        need_full;
    logic [NEED_W-1:0]     need;
    logic                  size_ok;
    logic                  fit_found;
    logic [BASE_W-1:0]     fit_base;
    logic                  slot_avail;
    logic [TID_W-1:0]      slot_idx;
    logic                  grant;
    outcome_t              outcome;

    // Round the request to blocks and check the legal size range.
    always_comb begin
        need_full = ({1'b0, alloc_regs} + (REQ_W+1)'(BLOCK_REGS - 1)) >> SHIFT;
        need      = need_full[NEED_W-1:0];
        size_ok   = (alloc_regs != '0) && (int'(alloc_regs) <= MAX_REQ_REGS);
    end

    rfa_fit_finder #(.NUM_BLOCKS(NUM_BLOCKS), .NEED_W(NEED_W)) u_fit (
        .free_mask (free_mask),
        .need      (size_ok ? need : NEED_W'(1)),
        .found     (fit_found),
        .base      (fit_base)
    );

    rfa_slot_table #(.MAX_THREADS(MAX_THREADS), .NUM_BLOCKS(NUM_BLOCKS),
                     .NEED_W(NEED_W)) u_slots (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (grant),
        .wr_tid     (slot_idx),
        .wr_base    (fit_base),
        .wr_len     (need),
        .ret_en     (retire_valid),
        .ret_tid    (retire_tid),
        .slot_avail (slot_avail),
        .slot_idx   (slot_idx),
        .ret_blocks (ret_blocks),
        .live_count (live_threads)
    );

    // Decide the outcome of the current request.
    always_comb begin
        if (!size_ok)                      outcome = OUT_ERR;
        else if (!slot_avail || !fit_found) outcome = OUT_FULL;
        else                               outcome = OUT_OK;
        grant = alloc_valid && (outcome == OUT_OK);
    end

    // Blocks claimed by a grant this cycle.
    always_comb begin
        grant_mask = '0;
        for (int j = 0; j < NUM_BLOCKS; j++) begin
            if (grant && j >= int'(fit_base) && j < int'(fit_base) + int'(need))
                grant_mask[j] = 1'b1;
        end
    end

    // Free mask update: retired blocks return, granted blocks leave.
    always_ff @(posedge clk) begin
        if (!rst_n) free_mask <= '1;
        else        free_mask <= (free_mask | ret_blocks) & ~grant_mask;
    end

    // Registered answer to the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_ok    <= 1'b0;
            resp_err   <= 1'b0;
            resp_full  <= 1'b0;
            resp_tid   <= '0;
            resp_base  <= '0;
        end else begin
            resp_valid <= alloc_valid;
            resp_ok    <= alloc_valid && outcome == OUT_OK;
            resp_err   <= alloc_valid && outcome == OUT_ERR;
            resp_full  <= alloc_valid && outcome == OUT_FULL;
            resp_tid   <= grant ? slot_idx : '0;
            resp_base  <= grant ? fit_base : '0;
        end
    end

    assign free_blocks = FB_W'($countones(free_mask));

    AST_SINGLE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> ($countones({resp_ok, resp_err, resp_full}) == 1)); // R11
    AST_ONE_CYCLE_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_valid |=> resp_valid); // R11
    AST_NO_SPURIOUS_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        !alloc_valid |=> !resp_valid); // R11
    AST_BAD_SIZE_KEEPS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid && !size_ok && !retire_valid) |=> $stable(free_mask)); // R5
    AST_GRANT_ON_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> ((free_mask & grant_mask) == grant_mask)); // R7
    AST_RETIRE_FREES_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
        retire_valid |-> ((free_mask & ret_blocks) == '0)); // R8
endmodule

// File: tb/rfa_alloc_test.sv
module rfa_alloc_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       alloc_valid = 1'b0;
    logic [9:0] alloc_regs = '0;
    logic       retire_valid = 1'b0;
    logic [3:0] retire_tid = '0;
    logic       resp_valid, resp_ok, resp_err, resp_full;
    logic [3:0] resp_tid;
    logic [4:0] resp_base;
    logic [3:0] live_threads;
    logic [5:0] free_blocks;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // Behavioural reference state.
    bit m_free [32];
    bit m_busy [10];
    int m_base [10];
    int m_len  [10];

    always #2 clk = ~clk;

    rfa_alloc uut (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_regs(alloc_regs),
        .retire_valid(retire_valid), .retire_tid(retire_tid),
        .resp_valid(resp_valid), .resp_ok(resp_ok), .resp_err(resp_err),
        .resp_full(resp_full), .resp_tid(resp_tid), .resp_base(resp_base),
        .live_threads(live_threads), .free_blocks(free_blocks)
    );

    task automatic check(input bit cond, input string tag, input string what,
                         input int act, input int exp);
        total++;
        if (!cond) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int m_live();
        int c = 0;
        for (int t = 0; t < 10; t++) if (m_busy[t]) c++;
        return c;
    endfunction

    function automatic int m_freecnt();
        int c = 0;
        for (int j = 0; j < 32; j++) if (m_free[j]) c++;
        return c;
    endfunction

    // One cycle: drive, predict, clock, update model, compare at negedge.
    task automatic cyc(input bit av, input int nregs, input bit rv,
                       input int rtid, input string tag);
        int need, slot, fb, outc;
        bit ok;
        alloc_valid  = av;
        alloc_regs   = 10'(nregs);
        retire_valid = rv;
        retire_tid   = 4'(rtid);
        need = (nregs + 31) / 32;
        slot = -1;
        fb   = -1;
        for (int t = 9; t >= 0; t--) if (!m_busy[t]) slot = t;
        if (nregs > 0 && nregs <= 256) begin
            for (int b = 32 - need; b >= 0; b--) begin
                ok = 1'b1;
                for (int j = b; j < b + need; j++) if (!m_free[j]) ok = 1'b0;
                if (ok) fb = b;
            end
        end
        if (nregs == 0 || nregs > 256) outc = 1;
        else if (slot < 0 || fb < 0)   outc = 2;
        else                           outc = 0;
        @(posedge clk);
        if (rv && rtid < 10 && m_busy[rtid]) begin
            for (int j = m_base[rtid]; j < m_base[rtid] + m_len[rtid]; j++)
                m_free[j] = 1'b1;
            m_busy[rtid] = 1'b0;
        end
        if (av && outc == 0) begin
            m_busy[slot] = 1'b1;
            m_base[slot] = fb;
            m_len[slot]  = need;
            for (int j = fb; j < fb + need; j++) m_free[j] = 1'b0;
        end
        @(negedge clk);
        check(resp_valid == av, tag, "resp_valid", resp_valid, av);
        if (av) begin
            check({resp_ok, resp_err, resp_full} ==
                  (outc == 0 ? 3'b100 : outc == 1 ? 3'b010 : 3'b001),
                  tag, "outcome ok/err/full", {resp_ok, resp_err, resp_full},
                  (outc == 0 ? 4 : outc == 1 ? 2 : 1));
            if (outc == 0) begin
                check(resp_tid == 4'(slot), tag, "resp_tid", resp_tid, slot);
                check(resp_base == 5'(fb), tag, "resp_base", resp_base, fb);
            end
        end
        check(live_threads == 4'(m_live()), tag, "live_threads",
              live_threads, m_live());
        check(free_blocks == 6'(m_freecnt()), tag, "free_blocks",
              free_blocks, m_freecnt());
    endtask

    task automatic retire_all();
        for (int t = 0; t < 10; t++) cyc(1'b0, 0, 1'b1, t, "R8 drain");
    endtask

    initial begin
        for (int j = 0; j < 32; j++) m_free[j] = 1'b1;
        for (int t = 0; t < 10; t++) begin
            m_busy[t] = 1'b0; m_base[t] = 0; m_len[t] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check(resp_valid == 1'b0, "R1", "resp_valid", resp_valid, 0);
        check(live_threads == 0, "R1", "live_threads", live_threads, 0);
        check(free_blocks == 32, "R1", "free_blocks", free_blocks, 32);
        rst_n = 1'b1;
        cyc(1'b0, 0, 1'b0, 0, "R11 idle");
        // R2/R3/R4: rounding and first fit from empty
        cyc(1'b1, 1,   1'b0, 0, "R2 one reg");
        cyc(1'b1, 33,  1'b0, 0, "R2 33 regs");
        cyc(1'b1, 0,   1'b0, 0, "R5 zero");
        cyc(1'b1, 257, 1'b0, 0, "R5 257");
        cyc(1'b1, 1023,1'b0, 0, "R5 1023");
        cyc(1'b1, 256, 1'b0, 0, "R2 256 regs");
        cyc(1'b1, 96,  1'b0, 0, "R2 96 regs");
        // R9: retire idle and out of range slots
        cyc(1'b0, 0, 1'b1, 9,  "R9 idle slot");
        cyc(1'b0, 0, 1'b1, 12, "R9 out of range");
        // R3/R4: hole reuse
        cyc(1'b0, 0, 1'b1, 1, "R8 retire t1");
        cyc(1'b1, 64, 1'b0, 0, "R3 hole reuse");
        cyc(1'b1, 32, 1'b0, 0, "R4 next slot");
        // R8: same-cycle retire not visible
        cyc(1'b1, 32, 1'b1, 0, "R8 same cycle");
        cyc(1'b1, 32, 1'b0, 0, "R8 next cycle");
        retire_all();
        // R10 / R6: ten threads of 96, then one more
        for (int k = 0; k < 10; k++) cyc(1'b1, 96, 1'b0, 0, "R10 fill");
        cyc(1'b1, 32, 1'b0, 0, "R6 all slots busy");
        // R7: fragmentation, enough total blocks but no run
        cyc(1'b0, 0, 1'b1, 1, "R8 frag a");
        cyc(1'b0, 0, 1'b1, 3, "R8 frag b");
        cyc(1'b0, 0, 1'b1, 5, "R8 frag c");
        cyc(1'b1, 128, 1'b0, 0, "R7 no run");
        cyc(1'b1, 96,  1'b0, 0, "R7 fits hole");
        cyc(1'b1, 64,  1'b0, 0, "R7 tail run");
        retire_all();
        cyc(1'b1, 256, 1'b0, 0, "R3 big a");
        cyc(1'b1, 256, 1'b0, 0, "R3 big b");
        cyc(1'b1, 256, 1'b0, 0, "R3 big c");
        cyc(1'b1, 256, 1'b0, 0, "R3 big d");
        cyc(1'b1, 1,   1'b0, 0, "R7 file full");
        cyc(1'b0, 0, 1'b0, 0, "R11 idle end");
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule